// File: doc/BRIEF.md
# I2C Master Controller with Register Interface

This block is a single-master I2C controller operated by software through six small registers: control, status, data, own-address, event and write-ready. Software places the address byte in the data register and writes the status register to issue START in transmit or receive mode. Each later byte starts when software writes the control register with the pending bit set. The controller divides the system clock to form SCL and shifts bytes MSB first on SDA. It samples the slave's ACK after transmitted bytes and drives ACK or NAK after received bytes. It generates STOP when software clears the busy bit.

The handshake between software and the controller works at byte level. A pending flag in the control register marks that a byte and its ACK clock are done. A separate event register flags byte completion, START and STOP, and software clears each flag by writing 1 to it. Every accepted register write is absorbed over a fixed number of cycles. During that window the ready register reads nonzero, and software polls it before each access. SCL and SDA are open-drain: an output of 1 releases the line.

Top module: `i2c_reg_master`

Register select codes: 0 control, 1 status, 2 data, 3 own-address, 4 event, 5 ready.

## Requirements
- R1: After reset the control, status, event, own-address and ready registers read 0, and scl_o and sda_o are both 1.
- R2: Writing status bits 7, 5 and 4 all set while idle issues START. Status bit 6 selects the direction (0xF0 transmit, 0xB0 receive). Status bit 5 reads 1 while a transfer is active. Event bit 12 sets once the START condition is done.
- R3: The SCL period is (control bit 6 ? 32 : 16) × (control bits 3:0 + 1) system clocks. Outside START and STOP, SDA changes only while SCL is low.
- R4: Bytes go out MSB first, and the first byte is the data register content at START. Control bit 4 (pending) sets after the ninth clock of each byte, and event bit 8 sets with it. A control write with bit 4 set starts the next byte.
- R5: Status bit 0 holds the ACK level sampled after each transmitted byte, address bytes included: 0 for ACK, 1 for NAK.
- R6: In receive mode the data register holds the received byte once pending sets, and the byte stays stable while pending is set. The master drives ACK (SDA low) if control bit 7 is 1 and NAK otherwise.
- R7: Clearing status bit 5 during a transfer makes the controller generate STOP once the current byte is done. Status bit 5 then reads 0 and event bit 13 sets.
- R8: Writing 1 to event bit 8, 12 or 13 clears that bit. Bits written with 0 keep their value.
- R9: After an accepted write the ready register reads nonzero for WR_LAT cycles (default 2). Any register write made during that window is ignored.
- R10: The own-address register reads back what was written and has no effect on the bus.
- R11: A status write with bit 4 clear issues no START, and both lines stay high.
- R12: Control bits 13:8 are stored and read back. They have no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 3 | Register select code |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the selected register (combinational) |
| scl_o | output | 1 | SCL drive (1 releases the line) |
| sda_o | output | 1 | SDA drive (1 releases the line) |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The hardest states to reach from the ports are a NAK on a data byte after the address was acknowledged, and the master's own NAK on the final received byte. Both depend on what the slave does inside the ninth clock. The bench therefore contains a behavioural slave that decodes START, STOP and each bus byte. This slave can be told to refuse a chosen data byte, supplies read bytes and records the master's ACK level. A transfer to a foreign address covers the address NAK. The ignored-write window is reached by firing a raw write strobe one cycle after an accepted write, without polling the ready register first.

// File: rtl/i2c_reg_master_pkg.sv
package i2c_reg_master_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_BITS, ST_HOLD, ST_STOP} eng_st_e;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_DATA = 3'd2;
  localparam logic [2:0] REG_OWN  = 3'd3;
  localparam logic [2:0] REG_EVT  = 3'd4;
  localparam logic [2:0] REG_RDY  = 3'd5;
endpackage

// File: rtl/i2c_quarter_tick.sv
module i2c_quarter_tick #(
  parameter int PRESC_W = 4,
  parameter int BASE_LO = 16,
  parameter int BASE_HI = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               div_sel_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);
  localparam int Q_LO = BASE_LO / 4;
  localparam int Q_HI = BASE_HI / 4;
  localparam int CW   = $clog2(Q_HI * (1 << PRESC_W)) + 1;

  logic [CW-1:0] cnt_q, qlen, mult, limit;

  assign qlen   = div_sel_i ? CW'(Q_HI) : CW'(Q_LO);
  assign mult   = CW'(presc_i) + CW'(1);
  assign limit  = qlen * mult - CW'(1);
  assign tick_o = en_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end

  // R3: quarter ticks never come back to back
  a_r3_tick_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_reg_master_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic       tx_mode_i,
  input  logic       go_i,
  input  logic       stop_i,
  input  logic       ack_en_i,
  input  logic       ld_i,
  input  logic [7:0] ld_data_i,
  input  logic       sda_i,
  output logic       scl_o,
  output logic       sda_o,
  output logic       busy_o,
  output logic       pend_o,
  output logic       nak_o,
  output logic [7:0] data_o,
  output logic       ev_start_o,
  output logic       ev_byte_o,
  output logic       ev_stop_o
);
  eng_st_e    st_q;
  logic [1:0] q_q;
  logic [3:0] bit_q;
  logic [7:0] dat_q;
  logic       tx_mode_q, first_q, nak_q, stop_req_q, scl_q, sda_q;
  logic       rx_byte, tx_bit, last_q;

  assign rx_byte = !tx_mode_q && !first_q;
  assign last_q  = (q_q == 2'd3) && tick_i;
  assign tx_bit  = (bit_q == 4'd8) ? (rx_byte ? !ack_en_i : 1'b1)
                                   : (rx_byte ? 1'b1 : dat_q[7]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; q_q <= '0; bit_q <= '0; dat_q <= '0;
      tx_mode_q <= 1'b0; first_q <= 1'b0; nak_q <= 1'b0; stop_req_q <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      if (stop_i && st_q != ST_IDLE) stop_req_q <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q <= ST_START; q_q <= '0; bit_q <= '0;
            tx_mode_q <= tx_mode_i; first_q <= 1'b1; nak_q <= 1'b0;
          end else if (ld_i) dat_q <= ld_data_i;
        end
        ST_START: begin
          if (ld_i) dat_q <= ld_data_i;
          if (tick_i) begin
            q_q <= q_q + 2'd1;
            if (q_q == 2'd1) sda_q <= 1'b0;
            if (q_q == 2'd3) begin scl_q <= 1'b0; st_q <= ST_BITS; end
          end
        end
        ST_BITS: begin
          if (tick_i) begin
            q_q <= q_q + 2'd1;
            case (q_q)
              2'd0: sda_q <= tx_bit;
              2'd1: scl_q <= 1'b1;
              2'd2: begin
                if (bit_q < 4'd8) dat_q <= {dat_q[6:0], sda_i};
                else if (!rx_byte) nak_q <= sda_i;
              end
              default: begin
                scl_q <= 1'b0;
                if (bit_q == 4'd8) begin st_q <= ST_HOLD; first_q <= 1'b0; end
                else bit_q <= bit_q + 4'd1;
              end
            endcase
          end
        end
        ST_HOLD: begin
          if (stop_req_q) begin st_q <= ST_STOP; q_q <= '0; end
          else if (go_i) begin st_q <= ST_BITS; q_q <= '0; bit_q <= '0; end
          else if (ld_i) dat_q <= ld_data_i;
        end
        default: begin
          if (tick_i) begin
            q_q <= q_q + 2'd1;
            case (q_q)
              2'd0: sda_q <= 1'b0;
              2'd1: scl_q <= 1'b1;
              2'd2: sda_q <= 1'b1;
              default: begin st_q <= ST_IDLE; stop_req_q <= 1'b0; end
            endcase
          end
        end
      endcase
    end
  end

  assign scl_o      = scl_q;
  assign sda_o      = sda_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign pend_o     = (st_q == ST_HOLD);
  assign nak_o      = nak_q;
  assign data_o     = dat_q;
  assign ev_start_o = (st_q == ST_START) && last_q;
  assign ev_byte_o  = (st_q == ST_BITS) && last_q && (bit_q == 4'd8);
  assign ev_stop_o  = (st_q == ST_STOP) && last_q;

  // R3: data line moves only while the clock is low
  a_r3_sda_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BITS && !$stable(sda_q)) |-> !scl_q);
  // R3: SCL edges only follow a quarter tick
  a_r3_scl_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_q) |-> $past(tick_i));
  // R4: byte completion leaves the engine pending
  a_r4_pend_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_byte_o |=> pend_o);
  // R7: busy only drops after a STOP condition
  a_r7_idle_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(ev_stop_o));
endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master
  import i2c_reg_master_pkg::*;
#(
  parameter int PRESC_W = 4,
  parameter int WR_LAT  = 2,
  parameter int BASE_LO = 16,
  parameter int BASE_HI = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  reg_sel_i,
  input  logic        reg_we_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        scl_o,
  output logic        sda_o,
  input  logic        sda_i
);
  localparam int LW = $clog2(WR_LAT + 1);

  logic [LW-1:0]      wr_cnt_q;
  logic [5:0]         ie_q;
  logic               ack_en_q, div_q, oe_q;
  logic [PRESC_W-1:0] presc_q;
  logic [1:0]         mode_q;
  logic [7:0]         own_q;
  logic [2:0]         evt_q;   // {stop, start, byte}
  logic               acc, wr_ctrl, wr_stat;
  logic               tick, busy, pend, nak, eng_scl, eng_sda;
  logic               ev_start, ev_byte, ev_stop;
  logic [7:0]         data;

  assign acc     = reg_we_i && (wr_cnt_q == '0);
  assign wr_ctrl = acc && reg_sel_i == REG_CTRL;
  assign wr_stat = acc && reg_sel_i == REG_STAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt_q <= '0; ie_q <= '0; ack_en_q <= 1'b0; div_q <= 1'b0;
      presc_q <= '0; mode_q <= '0; oe_q <= 1'b0; own_q <= '0; evt_q <= '0;
    end else begin
      if (acc) wr_cnt_q <= LW'(WR_LAT);
      else if (wr_cnt_q != '0) wr_cnt_q <= wr_cnt_q - LW'(1);
      if (wr_ctrl) begin
        ie_q <= reg_wdata_i[13:8]; ack_en_q <= reg_wdata_i[7];
        div_q <= reg_wdata_i[6];   presc_q <= reg_wdata_i[PRESC_W-1:0];
      end
      if (wr_stat) begin
        mode_q <= reg_wdata_i[7:6]; oe_q <= reg_wdata_i[4];
      end
      if (acc && reg_sel_i == REG_OWN) own_q <= reg_wdata_i[7:0];
      evt_q <= (evt_q & ~((acc && reg_sel_i == REG_EVT) ?
                 {reg_wdata_i[13], reg_wdata_i[12], reg_wdata_i[8]} : 3'b000))
             | {ev_stop, ev_start, ev_byte};
    end
  end

  i2c_quarter_tick #(.PRESC_W(PRESC_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_tick (
    .clk_i, .rst_ni, .en_i(busy), .div_sel_i(div_q), .presc_i(presc_q), .tick_o(tick)
  );

  i2c_byte_engine u_eng (
    .clk_i, .rst_ni, .tick_i(tick),
    .start_i(wr_stat && reg_wdata_i[7] && reg_wdata_i[5] && reg_wdata_i[4] && !busy),
    .tx_mode_i(reg_wdata_i[6]),
    .go_i(wr_ctrl && reg_wdata_i[4]),
    .stop_i(wr_stat && !reg_wdata_i[5]),
    .ack_en_i(ack_en_q),
    .ld_i(acc && reg_sel_i == REG_DATA), .ld_data_i(reg_wdata_i[7:0]),
    .sda_i, .scl_o(eng_scl), .sda_o(eng_sda), .busy_o(busy), .pend_o(pend),
    .nak_o(nak), .data_o(data),
    .ev_start_o(ev_start), .ev_byte_o(ev_byte), .ev_stop_o(ev_stop)
  );

  assign scl_o = oe_q ? eng_scl : 1'b1;
  assign sda_o = oe_q ? eng_sda : 1'b1;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_sel_i)
      REG_CTRL: reg_rdata_o = {2'b00, ie_q, ack_en_q, div_q, 1'b0, pend, 4'(presc_q)};
      REG_STAT: reg_rdata_o = {8'h00, mode_q, busy, oe_q, 3'b000, nak};
      REG_DATA: reg_rdata_o = {8'h00, data};
      REG_OWN:  reg_rdata_o = {8'h00, own_q};
      REG_EVT:  reg_rdata_o = {2'b00, evt_q[2], evt_q[1], 3'b000, evt_q[0], 8'h00};
      REG_RDY:  reg_rdata_o = 16'(wr_cnt_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  // R9: a write inside the absorb window leaves registers untouched
  a_r9_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && wr_cnt_q != '0 && reg_sel_i == REG_OWN) |=> $stable(own_q));
endmodule

// File: tb/i2c_reg_master_bench.sv
`timescale 1ns/1ps
module i2c_reg_master_bench;
  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0]  sel = '0;
  logic [15:0] wdata = '0, rdata;
  logic        scl_o, sda_o, slv_sda = 1'b1;
  wire         sda_line = sda_o & slv_sda;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_reg_master u_i2c_reg_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_line)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---- behavioural slave and bus monitor (scoreboard consumer)
  logic [7:0] exp_q[$];
  logic [7:0] shreg, tx_byte;
  logic [7:0] rd_mem[2];
  int  bcnt = 0, byte_no = 0, nak_at = -1, rd_ptr = 0, start_cnt = 0, stop_cnt = 0;
  bit  first = 0, rd_dir = 0, match = 0, rd_act = 0, last_mack = 0;
  time t_prev = 0, last_per = 0;

  always @(negedge sda_line) if (scl_o === 1'b1) begin
    start_cnt++; bcnt = 0; first = 1; byte_no = 0; rd_ptr = 0; rd_act = 0; slv_sda = 1'b1;
  end
  always @(posedge sda_line) if (scl_o === 1'b1 && rst_n) stop_cnt++;

  always @(posedge scl_o) if (rst_n) begin
    if (bcnt >= 1 && bcnt <= 7) last_per = $time - t_prev;
    t_prev = $time;
    if (bcnt < 8) begin
      shreg = {shreg[6:0], sda_line};
      if (bcnt == 7) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++; $display("FAIL R4 unexpected bus byte actual=%h expected=none", shreg);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (shreg !== e) begin
            n_fail++; $display("FAIL R4 bus byte actual=%h expected=%h", shreg, e);
          end
        end
      end
    end else last_mack = !sda_line;
    bcnt++;
  end

  always @(negedge scl_o) if (rst_n) begin
    if (bcnt == 8) begin
      if (first) begin
        match = (shreg[7:1] == 7'h2A); rd_dir = shreg[0];
        slv_sda = match ? 1'b0 : 1'b1;
      end else if (rd_dir) slv_sda = 1'b1;
      else begin
        slv_sda = (byte_no == nak_at) ? 1'b1 : 1'b0;
        byte_no++;
      end
    end else if (bcnt == 9) begin
      bcnt = 0;
      if (match && rd_dir && (first || last_mack)) begin
        tx_byte = rd_mem[rd_ptr]; rd_ptr++; rd_act = 1; slv_sda = tx_byte[7];
      end else begin
        rd_act = 0; slv_sda = 1'b1;
      end
      first = 0;
    end else if (bcnt >= 1 && bcnt <= 7 && rd_act) slv_sda = tx_byte[7-bcnt];
  end

  // ---- register access (driver side)
  task automatic rd(input logic [2:0] s, output logic [15:0] v);
    @(negedge clk); sel = s; #1; v = rdata;
  endtask
  task automatic wait_rdy();
    logic [15:0] v;
    do rd(3'd5, v); while (v != 0);
  endtask
  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    wait_rdy();
    @(negedge clk); sel = s; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask
  task automatic wait_pend();
    logic [15:0] v;
    do rd(3'd0, v); while (!v[4]);
  endtask
  task automatic wait_idle();
    logic [15:0] v;
    do rd(3'd1, v); while (v[5]);
  endtask
  task automatic send(input logic [7:0] b, input logic [15:0] ctrl);
    exp_q.push_back(b); wr(3'd2, {8'h00, b}); wr(3'd0, ctrl); wait_pend();
  endtask

  initial begin
    logic [15:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(3'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(3'd1, v); chk("R1 stat", v, 16'h0000);
    rd(3'd4, v); chk("R1 event", v, 16'h0000);
    rd(3'd3, v); chk("R1 own", v, 16'h0000);
    rd(3'd5, v); chk("R1 ready", v, 16'h0000);
    chk("R1 lines", {14'd0, scl_o, sda_o}, 16'h0003);
    // R10
    wr(3'd3, 16'h0040); rd(3'd3, v); chk("R10 own readback", v, 16'h0040);
    rd(3'd1, v); chk("R10 no bus effect", {v[5], scl_o, sda_o}, 3'b011);
    // R12
    wr(3'd0, 16'h3F80); rd(3'd0, v); chk("R12 enables readback", v, 16'h3F80);
    // R9
    wr(3'd2, 16'h00AA);
    rd(3'd5, v); chk("R9 ready busy", {15'd0, v != 0}, 16'h0001);
    sel = 3'd2; wdata = 16'h0055; we = 1'b1;
    @(negedge clk); we = 1'b0;
    wait_rdy(); rd(3'd2, v); chk("R9 write ignored", v, 16'h00AA);
    // R11
    wr(3'd2, 16'h0054); wr(3'd1, 16'h00E0);
    repeat (40) @(negedge clk);
    rd(3'd1, v); chk("R11 not busy", {15'd0, v[5]}, 16'h0000);
    chk("R11 lines high", {14'd0, scl_o, sda_o}, 16'h0003);
    chk("R11 no start", 16'(start_cnt), 16'h0000);
    // R2 R4 R5 R8 R3 R7: write transfer
    wr(3'd0, 16'h0080);
    exp_q.push_back(8'h54); wr(3'd1, 16'h00F0);
    rd(3'd1, v); chk("R2 busy", {15'd0, v[5]}, 16'h0001);
    wait_pend();
    rd(3'd1, v); chk("R5 address ack", {15'd0, v[0]}, 16'h0000);
    rd(3'd4, v); chk("R2 R4 events", v, 16'h1100);
    wr(3'd4, 16'h0100); rd(3'd4, v); chk("R8 clear byte only", v, 16'h1000);
    wr(3'd4, 16'h0000); rd(3'd4, v); chk("R8 zero keeps", v, 16'h1000);
    wr(3'd4, 16'h1000); rd(3'd4, v); chk("R8 clear start", v, 16'h0000);
    send(8'h3C, 16'h0090);
    rd(3'd1, v); chk("R5 data ack", {15'd0, v[0]}, 16'h0000);
    chk("R3 period 16", 16'(last_per), 16'd128);
    send(8'hA5, 16'h0090);
    wr(3'd1, 16'h00D0); wait_idle();
    rd(3'd4, v); chk("R7 stop event", v & 16'h2000, 16'h2000);
    chk("R7 stop on bus", 16'(stop_cnt), 16'd1);
    chk("R4 all bytes seen", 16'(exp_q.size()), 16'd0);
    wr(3'd4, 16'h3100);
    // R5 data NAK, R3 slow divider
    nak_at = 1; wr(3'd0, 16'h00C1);
    exp_q.push_back(8'h54); wr(3'd2, 16'h0054); wr(3'd1, 16'h00F0); wait_pend();
    send(8'h11, 16'h00D1);
    rd(3'd1, v); chk("R5 first data ack", {15'd0, v[0]}, 16'h0000);
    send(8'h22, 16'h00D1);
    rd(3'd1, v); chk("R5 data nak", {15'd0, v[0]}, 16'h0001);
    chk("R3 period 64", 16'(last_per), 16'd512);
    wr(3'd1, 16'h00D0); wait_idle(); nak_at = -1;
    // R5 address NAK
    wr(3'd0, 16'h0080);
    exp_q.push_back(8'h60); wr(3'd2, 16'h0060); wr(3'd1, 16'h00F0); wait_pend();
    rd(3'd1, v); chk("R5 address nak", {15'd0, v[0]}, 16'h0001);
    wr(3'd1, 16'h00D0); wait_idle();
    // R6 receive
    rd_mem[0] = 8'hC3; rd_mem[1] = 8'h5A;
    exp_q.push_back(8'h55); wr(3'd2, 16'h0055); wr(3'd1, 16'h00B0); wait_pend();
    rd(3'd1, v); chk("R5 read address ack", {15'd0, v[0]}, 16'h0000);
    exp_q.push_back(8'hC3); wr(3'd0, 16'h0090); wait_pend();
    rd(3'd2, v); chk("R6 first byte", v, 16'h00C3);
    repeat (60) @(negedge clk);
    rd(3'd2, v); chk("R6 byte stable", v, 16'h00C3);
    chk("R6 master ack", {15'd0, last_mack}, 16'h0001);
    exp_q.push_back(8'h5A); wr(3'd0, 16'h0010); wait_pend();
    rd(3'd2, v); chk("R6 last byte", v, 16'h005A);
    chk("R6 master nak", {15'd0, last_mack}, 16'h0000);
    wr(3'd1, 16'h0090); wait_idle();
    rd(3'd4, v); chk("R7 stop after read", v & 16'h2000, 16'h2000);
    chk("R4 queue empty", 16'(exp_q.size()), 16'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule